// File: doc/BRIEF.md
# Sixteen-Bit Compare PWM Channel

This block is a single pulse-width channel built around a free-running 16-bit timebase that it keeps itself. A compare value picks the point in each 65536-count period at which the output rises. The output then stays high until the timebase rolls over, where it falls. The compare value therefore sets the low part of the period, and the duty cycle is (65536 - compare) / 65536.

Software loads the compare value one byte at a time. A low-byte write disarms the comparator, and the high-byte write that follows re-arms it. This keeps a half-written value from ever producing a match. Each match raises a sticky flag, which can be routed to an interrupt request. Software uses that request to time the next compare update. The timebase only moves, and events only fire, while the count enable is high.

Top module: `pwm16_channel`

## Requirements
- R1: The timebase `count` resets to 0. It increments by one on every clock where `cnt_en` is 1, holds when `cnt_en` is 0, and wraps from 0xFFFF to 0x0000.
- R2: While the channel is active, `pwm_out` is 1 for every counter value from `cmp_value` through 0xFFFF and 0 for smaller values. A compare of 0 keeps the output high through the wrap. A compare of 0xFFFF gives exactly one high clock per period.
- R3: A match and a rollover can fall in the same enabled cycle (compare 0xFFFF). When they do, the rollover wins and `pwm_out` is 0 once the counter reads 0, unless the compare value is 0.
- R4: A `wr_lo` strobe loads `wr_data` into bits 7:0 of `cmp_value` and clears `armed` at the next clock edge.
- R5: A `wr_hi` strobe loads `wr_data` into bits 15:8 of `cmp_value` and sets `armed` at the next clock edge. When both strobes arrive in one cycle, both bytes load and `armed` ends up 1.
- R6: The channel is active only while `armed`, `pwm_sel` and `wide_sel` are all 1. While it is inactive, `pwm_out` is 0. After re-arming, the output stays low until the next match.
- R7: An enabled match sets `match_flag` at the next edge. The flag stays set until a `flag_clr` strobe. If a match and a clear happen in the same cycle, the flag is set.
- R8: `irq` is 1 exactly when `match_flag`, `flag_en` and `irq_en` are all 1.
- R9: With `cnt_en` at 0, a counter that sits on the compare value produces no match event, and `match_flag` is not set.
- R10: After reset, `cmp_value` is 0x0000, and `armed`, `match_flag`, `irq` and `pwm_out` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cnt_en | input | 1 | Timebase advance and event qualifier |
| pwm_sel | input | 1 | PWM-select mode bit |
| wide_sel | input | 1 | 16-bit-select mode bit |
| wr_lo | input | 1 | Low-byte compare write strobe |
| wr_hi | input | 1 | High-byte compare write strobe |
| wr_data | input | 8 | Byte written by either strobe |
| flag_clr | input | 1 | Clears the match flag |
| flag_en | input | 1 | Match-flag enable for the interrupt |
| irq_en | input | 1 | Match-interrupt enable |
| pwm_out | output | 1 | PWM output |
| match_flag | output | 1 | Sticky match flag |
| irq | output | 1 | Interrupt request |
| count | output | 16 | Timebase value |
| cmp_value | output | 16 | Compare register |
| armed | output | 1 | Comparator enable bit |

## Verification
Some properties are checked on every cycle: the counter stepping and holding, the arming and disarming effect of each byte strobe, the forced-low output right after a rollover, the setting and stickiness of the match flag, and the stall rule that blocks flag setting. Other behaviour only the bench scenarios can show. These include the exact number of high clocks over a full period for several compare values, the overflow-over-match priority at 0xFFFF, and the set-over-clear race. They also include the behaviour of the mode-select combinations and the low output after re-arming until the next match.

// File: rtl/pwm16_pkg.sv
package pwm16_pkg;
  localparam int BYTE_W = 8;

  typedef struct packed {
    logic hit;    // enabled compare match this cycle
    logic wrap;   // enabled rollover from all ones this cycle
  } tb_evt_t;
endpackage

// File: rtl/pwm16_rst_sync.sv
module pwm16_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/pwm16_timebase.sv
module pwm16_timebase #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  output logic [CNT_W-1:0] count,
  output logic             at_max
);
  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] count_nxt;

  always_comb begin
    count_nxt = count_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   count_q <= '0;
    else if (adv) count_q <= count_nxt;
  end

  assign count  = count_q;
  assign at_max = &count_q;
endmodule

// File: rtl/pwm16_cmp_reg.sv
module pwm16_cmp_reg
  import pwm16_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [CNT_W-1:0]  cmp_value,
  output logic              armed
);
  // Upper part width; must not exceed one byte.
  localparam int HI_W = CNT_W - BYTE_W;

  logic [BYTE_W-1:0] lo_q, lo_nxt;
  logic [HI_W-1:0]   hi_q, hi_nxt;
  logic              arm_q, arm_nxt;

  always_comb begin
    lo_nxt  = lo_q;
    hi_nxt  = hi_q;
    arm_nxt = arm_q;
    if (wr_lo) begin
      lo_nxt  = wr_data;
      arm_nxt = 1'b0;
    end
    if (wr_hi) begin
      hi_nxt  = wr_data[HI_W-1:0];
      arm_nxt = 1'b1;   // high byte completes the sequence
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q  <= '0;
      hi_q  <= '0;
      arm_q <= 1'b0;
    end else begin
      if (wr_lo)         lo_q  <= lo_nxt;
      if (wr_hi)         hi_q  <= hi_nxt;
      if (wr_lo || wr_hi) arm_q <= arm_nxt;
    end
  end

  assign cmp_value = {hi_q, lo_q};
  assign armed     = arm_q;
endmodule

// File: rtl/pwm16_out_ctrl.sv
module pwm16_out_ctrl
  import pwm16_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    active,
  input  tb_evt_t evt,
  input  logic    flag_clr,
  output logic    level_q,
  output logic    flag_q
);
  logic level_nxt;
  logic flag_nxt;

  always_comb begin
    // rollover and inactivity dominate, then match
    if (!active || evt.wrap) level_nxt = 1'b0;
    else if (evt.hit)        level_nxt = 1'b1;
    else                     level_nxt = level_q;

    // set dominates clear
    if (evt.hit)       flag_nxt = 1'b1;
    else if (flag_clr) flag_nxt = 1'b0;
    else               flag_nxt = flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= 1'b0;
      flag_q  <= 1'b0;
    end else begin
      level_q <= level_nxt;
      flag_q  <= flag_nxt;
    end
  end
endmodule

// File: rtl/pwm16_channel.sv
module pwm16_channel
  import pwm16_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnt_en,
  input  logic              pwm_sel,
  input  logic              wide_sel,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              flag_clr,
  input  logic              flag_en,
  input  logic              irq_en,
  output logic              pwm_out,
  output logic              match_flag,
  output logic              irq,
  output logic [CNT_W-1:0]  count,
  output logic [CNT_W-1:0]  cmp_value,
  output logic              armed
);
  logic    rst_n_i;
  logic    at_max;
  logic    active;
  logic    equal;
  logic    level_q;
  tb_evt_t evt;

  pwm16_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  pwm16_timebase #(.CNT_W(CNT_W)) u_tb (
    .clk    (clk),
    .rst_n  (rst_n_i),
    .adv    (cnt_en),
    .count  (count),
    .at_max (at_max)
  );

  pwm16_cmp_reg #(.CNT_W(CNT_W)) u_cmp (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .wr_lo     (wr_lo),
    .wr_hi     (wr_hi),
    .wr_data   (wr_data),
    .cmp_value (cmp_value),
    .armed     (armed)
  );

  always_comb begin
    active   = armed & pwm_sel & wide_sel;
    equal    = active & (count == cmp_value);
    evt.hit  = equal & cnt_en;
    evt.wrap = at_max & cnt_en;
  end

  pwm16_out_ctrl u_out (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .active   (active),
    .evt      (evt),
    .flag_clr (flag_clr),
    .level_q  (level_q),
    .flag_q   (match_flag)
  );

  // the equal term lets the matching count itself read high
  assign pwm_out = active & (level_q | equal);
  assign irq     = match_flag & flag_en & irq_en;
endmodule

// File: rtl/pwm16_channel_chk.sv
module pwm16_channel_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cnt_en,
  input logic             wr_lo,
  input logic             wr_hi,
  input logic             flag_clr,
  input logic             pwm_out,
  input logic             match_flag,
  input logic             irq,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] cmp_value,
  input logic             armed
);
  p_cnt_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_en |=> $stable(count));

  p_cnt_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_en |=> count == $past(count) + 1'b1);

  p_wrap_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && (&count) && cmp_value != '0 && !wr_lo && !wr_hi) |=> !pwm_out);

  p_lo_disarm_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lo && !wr_hi) |=> !armed);

  p_hi_arm_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hi |=> armed);

  p_off_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> !pwm_out);

  p_flag_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && pwm_out && count == cmp_value) |=> match_flag);

  p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (match_flag && !flag_clr) |=> match_flag);

  p_irq_needs_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> match_flag);

  p_stall_no_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en && !match_flag) |=> !match_flag);
endmodule

bind pwm16_channel pwm16_channel_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cnt_en     (cnt_en),
  .wr_lo      (wr_lo),
  .wr_hi      (wr_hi),
  .flag_clr   (flag_clr),
  .pwm_out    (pwm_out),
  .match_flag (match_flag),
  .irq        (irq),
  .count      (count),
  .cmp_value  (cmp_value),
  .armed      (armed)
);

// File: tb/pwm16_channel_test.sv
module pwm16_channel_test;
  timeunit 1ns;
  timeprecision 1ps;

  logic        clk;
  logic        rst_n;
  logic        cnt_en, pwm_sel, wide_sel, wr_lo, wr_hi, flag_clr, flag_en, irq_en;
  logic [7:0]  wr_data;
  logic        pwm_out, match_flag, irq, armed;
  logic [15:0] count, cmp_value;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  pwm16_channel uut (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .pwm_sel(pwm_sel),
    .wide_sel(wide_sel), .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_data(wr_data),
    .flag_clr(flag_clr), .flag_en(flag_en), .irq_en(irq_en),
    .pwm_out(pwm_out), .match_flag(match_flag), .irq(irq),
    .count(count), .cmp_value(cmp_value), .armed(armed)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  typedef struct packed {
    logic        do_lo;
    logic        do_hi;
    logic [7:0]  lo;
    logic [7:0]  hi;
    logic        psel;
    logic        wsel;
    logic        exp_armed;
    logic        exp_pwm;
    logic [15:0] exp_cmp;
  } vec_t;

  // counter frozen at 0 for the whole table
  localparam vec_t TBL [0:6] = '{
    '{1'b1, 1'b0, 8'h34, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0, 16'h0034}, // R4
    '{1'b0, 1'b1, 8'h00, 8'h12, 1'b1, 1'b1, 1'b1, 1'b0, 16'h1234}, // R5
    '{1'b1, 1'b1, 8'h00, 8'h00, 1'b1, 1'b1, 1'b1, 1'b1, 16'h0000}, // R5 both
    '{1'b0, 1'b0, 8'h00, 8'h00, 1'b0, 1'b1, 1'b1, 1'b0, 16'h0000}, // R6
    '{1'b0, 1'b0, 8'h00, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0, 16'h0000}, // R6
    '{1'b0, 1'b0, 8'h00, 8'h00, 1'b1, 1'b1, 1'b1, 1'b1, 16'h0000}, // R2
    '{1'b1, 1'b0, 8'h00, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0, 16'h0000}  // R4 R6
  };

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // advance one edge, settle after it
  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic write_cmp(input logic [15:0] v);
    wr_lo = 1'b1; wr_data = v[7:0];  tick(); wr_lo = 1'b0;
    wr_hi = 1'b1; wr_data = v[15:8]; tick(); wr_hi = 1'b0;
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int high, bad;
    rst_n = 1'b0; cnt_en = 1'b0; pwm_sel = 1'b1; wide_sel = 1'b1;
    wr_lo = 1'b0; wr_hi = 1'b0; wr_data = '0; flag_clr = 1'b0;
    flag_en = 1'b1; irq_en = 1'b1;
    repeat (3) tick();
    // R10 reset state
    check("R10", "cmp", int'(cmp_value), 0);
    check("R10", "armed", int'(armed), 0);
    check("R10", "pwm", int'(pwm_out), 0);
    check("R10", "flag", int'(match_flag), 0);
    check("R10", "irq", int'(irq), 0);
    check("R1", "reset count", int'(count), 0);
    rst_n = 1'b1;
    repeat (3) tick();

    // vector table, counter held at 0
    for (int k = 0; k < 7; k++) begin
      wr_lo = TBL[k].do_lo; wr_hi = TBL[k].do_hi;
      wr_data = TBL[k].do_hi && !TBL[k].do_lo ? TBL[k].hi : TBL[k].lo;
      pwm_sel = TBL[k].psel; wide_sel = TBL[k].wsel;
      if (TBL[k].do_lo && TBL[k].do_hi) wr_data = TBL[k].lo; // lo==hi in that row
      tick();
      wr_lo = 1'b0; wr_hi = 1'b0;
      check("R4 R5", $sformatf("table %0d cmp", k), int'(cmp_value), int'(TBL[k].exp_cmp));
      check("R4 R5", $sformatf("table %0d armed", k), int'(armed), int'(TBL[k].exp_armed));
      check("R2 R6", $sformatf("table %0d pwm", k), int'(pwm_out), int'(TBL[k].exp_pwm));
      check("R9", $sformatf("table %0d flag", k), int'(match_flag), 0);
    end
    pwm_sel = 1'b1; wide_sel = 1'b1;

    // period 1, compare 3
    write_cmp(16'h0003);
    cnt_en = 1'b1;
    high = 0; bad = 0;
    for (int i = 0; i < 65536; i++) begin
      if (int'(count) != i) bad++;
      if (pwm_out) high++;
      if (i == 3) check("R7", "flag before match edge", int'(match_flag), 0);
      if (i == 4) begin
        check("R7", "flag after match", int'(match_flag), 1);
        check("R8", "irq both enables", int'(irq), 1);
      end
      if (i == 10) flag_clr = 1'b1;
      if (i == 11) begin
        flag_clr = 1'b0;
        check("R7", "flag cleared", int'(match_flag), 0);
      end
      tick();
    end
    check("R1", "count sequence errors", bad, 0);
    check("R2", "high clocks cmp 3", high, 65533);
    check("R1", "wrapped count", int'(count), 0);
    check("R2", "low after wrap", int'(pwm_out), 0);

    // period 2, compare 0xFFFF, set/clear race at the match
    cnt_en = 1'b0;
    write_cmp(16'hFFFF);
    cnt_en = 1'b1;
    high = 0;
    for (int i = 0; i < 65536; i++) begin
      if (pwm_out) high++;
      if (i == 65535) begin
        check("R2", "high on last count", int'(pwm_out), 1);
        flag_clr = 1'b1;
      end
      tick();
    end
    flag_clr = 1'b0;
    check("R2", "high clocks cmp FFFF", high, 1);
    check("R7", "set wins over clear", int'(match_flag), 1);
    check("R3", "overflow beats match", int'(pwm_out), 0);
    irq_en = 1'b0;
    #1;
    check("R8", "irq masked", int'(irq), 0);

    // stall, compare 0
    cnt_en = 1'b0;
    flag_clr = 1'b1; tick(); flag_clr = 1'b0;
    repeat (3) tick();
    check("R1", "held count", int'(count), 0);
    wr_lo = 1'b1; wr_data = 8'h00; tick(); wr_lo = 1'b0;
    check("R4", "lo write disarms", int'(armed), 0);
    check("R6", "disarmed low", int'(pwm_out), 0);
    wr_hi = 1'b1; wr_data = 8'h00; tick(); wr_hi = 1'b0;
    check("R2", "cmp 0 high", int'(pwm_out), 1);
    repeat (3) tick();
    check("R9", "no flag while stalled on match", int'(match_flag), 0);
    cnt_en = 1'b1;
    high = 0;
    for (int i = 0; i < 20; i++) begin
      tick();
      if (pwm_out) high++;
    end
    check("R2", "cmp 0 stays high", high, 20);
    check("R7", "flag after enabled match", int'(match_flag), 1);

    // disarm while high, re-arm waits for match
    wr_lo = 1'b1; wr_data = 8'h00; tick(); wr_lo = 1'b0;
    check("R4", "disarm mid-high", int'(pwm_out), 0);
    wr_hi = 1'b1; wr_data = 8'h00; tick(); wr_hi = 1'b0;
    check("R5", "re-armed", int'(armed), 1);
    high = 0;
    for (int i = 0; i < 5; i++) begin
      if (pwm_out) high++;
      tick();
    end
    check("R6", "low until next match", high, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule